// File: doc/BRIEF.md
# Per-Timeslot Idle Code Inserter

This block sits in the E1 transmit path, between the backplane and the line. It carries a serial stream of 32 eight-bit timeslots per frame. Any timeslot can be made to carry one shared, programmable 8-bit idle code in place of the backplane data. A 32-bit selection mask is held as four 8-bit registers, one bit per timeslot.

The stream moves one bit per clock enable, most significant bit first. An external counter supplies the timeslot number and the bit position within the timeslot. The replace-or-pass decision, and the code used, are taken at the first bit of each timeslot and held for the whole byte. A change to the mask or the code during a timeslot therefore never splits a byte.

A mode input hands channel replacement over to a different method. While it is 1, this block passes all data through untouched.

Top module: `idle_ts_inserter`

## Requirements
- R1: While `rst_n` is low, `ser_out` is 0, and it stays 0 until the first enabled bit after reset is released.
- R2: When the mask bit for the current timeslot is 1 and `pc_mode` is 0, the eight output bits of that timeslot are the idle code, sent most significant bit first (bit position 0 carries code bit 7).
- R3: When the mask bit for the current timeslot is 0, every output bit equals the `ser_in` bit driven with it.
- R4: Timeslot k (0 to 31) is controlled by bit (k mod 8) of mask register (k div 8). Register 0 bit 0 controls timeslot 0, and register 3 bit 7 controls timeslot 31.
- R5: While `pc_mode` is 1 at a timeslot's first bit, that whole timeslot passes `ser_in` through, whatever the mask holds.
- R6: Mask, code and mode values are sampled only on the enabled bit with `bit_pos` = 0. Changes at any later bit of the timeslot have no effect until the next timeslot.
- R7: `ser_out` takes a new value only in the cycle after an enabled bit (one clock of latency). On cycles with `bit_en` low, it holds its value.
- R8: Every masked timeslot in a frame carries the same code value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe: the current bit is valid |
| ser_in | input | 1 | Backplane serial data bit |
| ts_idx | input | 5 | Timeslot number of the current bit, 0 to 31 |
| bit_pos | input | 3 | Bit position within the timeslot, 0 = MSB |
| mask_regs | input | 4x8 | Timeslot selection registers; register g bit b selects timeslot 8g+b |
| idle_code | input | 8 | Shared replacement code |
| pc_mode | input | 1 | 1 = another replacement method owns the channels; this block passes data through |
| ser_out | output | 1 | Line-side serial data bit |

## Verification
The bench builds the block with its default parameters: 32 timeslots, 8-bit codes and four 8-bit mask registers. With these values, every register boundary (timeslots 7/8, 15/16, 23/24) and both ends of the frame can be reached. Whole frames are pushed through for a table of masks, codes and mode settings, and each output byte is compared with a model kept in the bench. Directed steps then change the mask, the code and the mode in the middle of a timeslot, check the hold between enables, and apply reset during traffic.

// File: rtl/idle_pkg.sv
package idle_pkg;

  // Source chosen for the bits of one timeslot
  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_IDLE = 1'b1
  } src_e;

  // Replace only when the timeslot is selected and the simple method is active
  function automatic src_e src_of(input logic mask_hit, input logic alt_mode);
    return (mask_hit && !alt_mode) ? SRC_IDLE : SRC_LINE;
  endfunction

endpackage

// File: rtl/idle_mask_select.sv
module idle_mask_select #(
  parameter int NUM_TS = 32,
  parameter int REG_W  = 8,
  localparam int TS_W    = $clog2(NUM_TS),
  localparam int REG_CNT = NUM_TS / REG_W
) (
  input  logic [REG_CNT-1:0][REG_W-1:0] mask_regs,
  input  logic [TS_W-1:0]               ts_idx,
  output logic                          mask_hit
);

  logic [NUM_TS-1:0] flat_mask;

  // Register g supplies timeslots g*REG_W .. g*REG_W+REG_W-1, LSB first
  for (genvar g = 0; g < REG_CNT; g++) begin : g_flat
    assign flat_mask[g*REG_W +: REG_W] = mask_regs[g];
  end

  function automatic logic bit_for_slot(input logic [NUM_TS-1:0] m,
                                        input logic [TS_W-1:0] ts);
    return m[ts];
  endfunction

  assign mask_hit = bit_for_slot(flat_mask, ts_idx);

endmodule

// File: rtl/idle_slot_latch.sv
module idle_slot_latch
  import idle_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int BP_W = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BP_W-1:0]   bit_pos,
  input  logic              mask_hit,
  input  logic              pc_mode,
  input  logic [CODE_W-1:0] idle_code,
  output src_e              slot_src,
  output logic [CODE_W-1:0] slot_code,
  output logic              slot_start
);

  src_e              held_src;
  logic [CODE_W-1:0] held_code;
  src_e              fresh_src;

  assign slot_start = bit_en && (bit_pos == '0);
  assign fresh_src  = src_of(mask_hit, pc_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_src  <= SRC_LINE;
      held_code <= '0;
    end else if (slot_start) begin
      held_src  <= fresh_src;
      held_code <= idle_code;
    end
  end

  // The first bit uses the fresh decision; later bits use the held one
  assign slot_src  = slot_start ? fresh_src : held_src;
  assign slot_code = slot_start ? idle_code : held_code;

  // R6: held decision and code move only at a timeslot boundary
  p_held_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> ($stable(held_src) && $stable(held_code)));

endmodule

// File: rtl/idle_bit_mux.sv
module idle_bit_mux
  import idle_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int BP_W = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BP_W-1:0]   bit_pos,
  input  logic              ser_in,
  input  src_e              slot_src,
  input  logic [CODE_W-1:0] slot_code,
  output logic              ser_out
);

  // MSB first: position 0 carries the top bit of the code
  function automatic logic code_bit(input logic [CODE_W-1:0] code,
                                    input logic [BP_W-1:0] pos);
    return code[CODE_W-1-int'(pos)];
  endfunction

  logic idle_bit;
  logic next_bit;

  assign idle_bit = code_bit(slot_code, bit_pos);
  assign next_bit = (slot_src == SRC_IDLE) ? idle_bit : ser_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ser_out <= 1'b0;
    else if (bit_en) ser_out <= next_bit;
  end

  // R7: no enable, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));

  // R3: line-sourced bits pass through unchanged
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_src == SRC_LINE) |=> (ser_out == $past(ser_in)));

  // R2: idle-sourced bits follow the code MSB first
  p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_src == SRC_IDLE) |=> (ser_out == $past(slot_code[CODE_W-1-int'(bit_pos)])));

endmodule

// File: rtl/idle_ts_inserter.sv
module idle_ts_inserter
  import idle_pkg::*;
#(
  parameter int NUM_TS = 32,
  parameter int CODE_W = 8,
  parameter int REG_W  = 8,
  localparam int TS_W    = $clog2(NUM_TS),
  localparam int BP_W    = $clog2(CODE_W),
  localparam int REG_CNT = NUM_TS / REG_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_en,
  input  logic                          ser_in,
  input  logic [TS_W-1:0]               ts_idx,
  input  logic [BP_W-1:0]               bit_pos,
  input  logic [REG_CNT-1:0][REG_W-1:0] mask_regs,
  input  logic [CODE_W-1:0]             idle_code,
  input  logic                          pc_mode,
  output logic                          ser_out
);

  logic              mask_hit;
  src_e              slot_src;
  logic [CODE_W-1:0] slot_code;
  logic              slot_start;

  idle_mask_select #(.NUM_TS(NUM_TS), .REG_W(REG_W)) u_sel (
    .mask_regs (mask_regs),
    .ts_idx    (ts_idx),
    .mask_hit  (mask_hit)
  );

  idle_slot_latch #(.CODE_W(CODE_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_pos    (bit_pos),
    .mask_hit   (mask_hit),
    .pc_mode    (pc_mode),
    .idle_code  (idle_code),
    .slot_src   (slot_src),
    .slot_code  (slot_code),
    .slot_start (slot_start)
  );

  idle_bit_mux #(.CODE_W(CODE_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_pos   (bit_pos),
    .ser_in    (ser_in),
    .slot_src  (slot_src),
    .slot_code (slot_code),
    .ser_out   (ser_out)
  );

  // R5: alternate mode at a boundary always yields pass-through
  p_mode_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && pc_mode) |-> (slot_src == SRC_LINE));

  // R4: a selected timeslot at a boundary with simple mode is replaced
  p_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !pc_mode && mask_regs[ts_idx / REG_W][ts_idx % REG_W]) |-> (slot_src == SRC_IDLE));

endmodule

// File: tb/test_idle_ts_inserter.sv
module test_idle_ts_inserter;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bit_en = 1'b0;
  logic            ser_in = 1'b0;
  logic [4:0]      ts_idx = '0;
  logic [2:0]      bit_pos = '0;
  logic [3:0][7:0] mask_regs = '0;
  logic [7:0]      idle_code = '0;
  logic            pc_mode = 1'b0;
  logic            ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  idle_ts_inserter i_idle_ts_inserter (
    .clk, .rst_n, .bit_en, .ser_in, .ts_idx, .bit_pos,
    .mask_regs, .idle_code, .pc_mode, .ser_out
  );

  // {mask[31:0], code[7:0], mode, seed[7:0]}
  localparam logic [48:0] VEC [7] = '{
    {32'h0000_0000, 8'hFF, 1'b0, 8'h11},  // R3 all pass
    {32'hFFFF_FFFF, 8'h54, 1'b0, 8'h22},  // R2 R8 all idle
    {32'h0000_0001, 8'hD5, 1'b0, 8'h33},  // R4 first slot
    {32'h8000_0000, 8'h7E, 1'b0, 8'h44},  // R4 last slot
    {32'h0101_0180, 8'h13, 1'b0, 8'h55},  // R4 register edges
    {32'hFFFF_FFFF, 8'h54, 1'b1, 8'h66},  // R5 mode overrides
    {32'hA5A5_5A5A, 8'hC3, 1'b0, 8'h77}   // R8 mixed
  };

  function automatic logic [7:0] line_byte(input logic [7:0] seed, input int ts);
    logic [7:0] t;
    t = 8'(ts * 37);
    return seed ^ t;
  endfunction

  function automatic logic [7:0] model_byte(input logic [31:0] m, input logic [7:0] c,
                                            input logic md, input int ts, input logic [7:0] d);
    logic sel;
    sel = ((m >> ts) & 32'd1) != 0;
    if (md) sel = 1'b0;
    return sel ? c : d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input int ts, input int pos, output logic o);
    @(negedge clk);
    ser_in  = b;
    ts_idx  = 5'(ts);
    bit_pos = 3'(pos);
    bit_en  = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    o = ser_out;
  endtask

  initial begin
    logic       o;
    logic [7:0] got;
    logic [7:0] din;
    logic [31:0] m;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 during reset", 32'(ser_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(ser_out), 32'h0);

    // Table walk: whole frames
    foreach (VEC[v]) begin
      m         = VEC[v][48:17];
      idle_code = VEC[v][16:9];
      pc_mode   = VEC[v][8];
      for (int g = 0; g < 4; g++) mask_regs[g] = m[g*8 +: 8];
      for (int ts = 0; ts < 32; ts++) begin
        din = line_byte(VEC[v][7:0], ts);
        for (int p = 0; p < 8; p++) begin
          drive_bit(din[7-p], ts, p, o);
          got[7-p] = o;
        end
        chk($sformatf("R2/R3/R4/R5/R8 vec%0d ts%0d", v, ts), 32'(got),
            32'(model_byte(m, VEC[v][16:9], VEC[v][8], ts, din)));
      end
    end

    // R6: mask and code change mid-slot ignored
    pc_mode = 1'b0;
    mask_regs = '0;
    mask_regs[0][5] = 1'b1;
    idle_code = 8'hA5;
    din = 8'h0F;
    for (int p = 0; p < 8; p++) begin
      if (p == 3) begin mask_regs = '0; idle_code = 8'h3C; end
      drive_bit(din[7-p], 5, p, o);
      got[7-p] = o;
    end
    chk("R6 code kept after mid-slot change", 32'(got), 32'hA5);

    // R6: mask set after the first bit does not take effect
    din = 8'h96;
    for (int p = 0; p < 8; p++) begin
      if (p == 1) mask_regs[0][6] = 1'b1;
      drive_bit(din[7-p], 6, p, o);
      got[7-p] = o;
    end
    chk("R6 late mask ignored", 32'(got), 32'h96);

    // R6: mode raised mid-slot does not stop replacement
    mask_regs[0][7] = 1'b1;
    din = 8'hF0;
    for (int p = 0; p < 8; p++) begin
      if (p == 2) pc_mode = 1'b1;
      drive_bit(din[7-p], 7, p, o);
      got[7-p] = o;
    end
    chk("R6 late mode ignored", 32'(got), 32'h3C);

    // R5: next slot sees mode at its boundary
    mask_regs[1][0] = 1'b1;
    din = 8'h81;
    for (int p = 0; p < 8; p++) begin
      drive_bit(din[7-p], 8, p, o);
      got[7-p] = o;
    end
    chk("R5 mode at boundary passes data", 32'(got), 32'h81);
    pc_mode = 1'b0;

    // R7: hold between enables and one-clock latency
    drive_bit(1'b1, 9, 0, o);
    chk("R7 value after enable", 32'(o), 32'h1);
    @(negedge clk);
    ser_in = 1'b0;
    @(negedge clk);
    chk("R7 hold without enable", 32'(ser_out), 32'h1);
    @(negedge clk);
    ser_in = 1'b0; ts_idx = 5'd9; bit_pos = 3'd1; bit_en = 1'b1;
    chk("R7 no change before edge", 32'(ser_out), 32'h1);
    @(negedge clk);
    bit_en = 1'b0;
    chk("R7 change one clock later", 32'(ser_out), 32'h0);

    // R1: reset during traffic
    drive_bit(1'b1, 10, 0, o);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", 32'(ser_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stays low after release", 32'(ser_out), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule